// File: doc/BRIEF.md
# Two-Level Routed Interrupt Controller

This block collects level-sensitive device interrupt lines and delivers them to up to four processors. Each line passes two gates before it can reach a processor. The first is a single global enable bit per source. The second is a mask bit for each pair of processor and source. Sources above a fixed index also need a routing bitmap, with one bit per processor, that names the processors allowed to take them. The lower, processor-local sources skip the routing check.

Software changes enables and masks by writing a source number to a dedicated set or clear register, not by writing bitmasks. The register bus has two views. The shared view holds the configuration word, the enable set and clear registers, and one routing word per source. The banked view acts on the processor named by `bus_cpu`: it holds that processor's mask set and clear registers and its acknowledge register. The acknowledge register returns the lowest-numbered source that is currently deliverable to that processor, or 1023 when none is. Reading it changes no state.

Top module: `twolvl_irq_ctrl`

## Requirements
- R1: Writing N to shared offset 0x30 sets the global enable of source N, and writing N to shared offset 0x34 clears it. A written value of NUM_SRC or more is ignored, including its low bits.
- R2: In the banked view (address bit 13 set), writing N to offset 0x48 masks source N for the processor on `bus_cpu`, and writing N to offset 0x4C unmasks it. Other processors' masks are not affected.
- R3: The routing word at shared offset 0x100 + 4*N holds, in bits [NUM_CPU-1:0], the processors allowed to take source N. It reads back in those bits with zeros above. For N > LOCAL_LAST, a source is not delivered to a processor whose routing bit is 0.
- R4: Sources 0 to LOCAL_LAST (28 by default) ignore routing. They reach a processor whenever they are asserted, globally enabled and unmasked for that processor.
- R5: Reading shared offset 0x00 returns NUM_SRC in bits [11:2], with all other bits 0.
- R6: Reading banked offset 0x44 returns in bits [9:0] the lowest-numbered source that is asserted, enabled, unmasked and routed for that processor. Bits [31:10] are 0.
- R7: The acknowledge read has no side effect. A source stays reported until its input drops, it is disabled, or it is masked.
- R8: `irq_req[c]` is high exactly when the acknowledge value for processor c is not 1023.
- R9: After reset, all global enables are 0, all masks are 1 and all routing words are 0. Every acknowledge value is therefore 1023, whatever the inputs are.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | Level interrupt inputs, one per source |
| bus_cpu | input | CPU_W | Processor issuing the access; selects the bank in the banked view |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 14 | Byte address; bit 13 selects the banked view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | NUM_CPU | Per-processor interrupt request |

## Verification
If an enable, mask or routing bit holds the wrong value, the error appears on the next acknowledge read or on `irq_req`. It shows as a source number that should not be there, or as 1023 where a source was expected. The bit is stored one cycle after the write, so the error is visible from that cycle on. An acknowledge read that wrongly cleared state would change the result of a second identical read. A decoder that wrapped an out-of-range number onto a real source would enable that source, and the next read would show it.

// File: rtl/twolvl_irq_pkg.sv
package twolvl_irq_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  localparam logic [12:0] OFF_CTRL    = 13'h000;
  localparam logic [12:0] OFF_EN_SET  = 13'h030;
  localparam logic [12:0] OFF_EN_CLR  = 13'h034;
  localparam logic [12:0] OFF_ROUTE   = 13'h100;
  localparam logic [12:0] OFF_ACK     = 13'h044;
  localparam logic [12:0] OFF_MSK_SET = 13'h048;
  localparam logic [12:0] OFF_MSK_CLR = 13'h04C;

  function automatic logic num_in_range(input logic [31:0] v, input int nsrc);
    return v < 32'(nsrc);
  endfunction

  function automatic logic [31:0] ctrl_word(input int nsrc);
    return 32'(nsrc) << 2;
  endfunction

  function automatic logic route_applies(input int n, input int local_last);
    return n > local_last;
  endfunction
endpackage

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 6,
  parameter int CPU_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_set,
  input  logic                       en_clr,
  input  logic                       msk_set,
  input  logic                       msk_clr,
  input  logic                       route_wr,
  input  logic [CPU_W-1:0]           cpu,
  input  logic [IDX_W-1:0]           num,
  input  logic [IDX_W-1:0]           route_idx,
  input  logic [NUM_CPU-1:0]         route_val,
  output logic [NUM_SRC-1:0]         gen_en,
  output logic [NUM_CPU*NUM_SRC-1:0] cpu_mask,
  output logic [NUM_SRC*NUM_CPU-1:0] route
);
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) gen_en[n] <= 1'b0;
      else if (en_set && num == IDX_W'(n)) gen_en[n] <= 1'b1;
      else if (en_clr && num == IDX_W'(n)) gen_en[n] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) route[n*NUM_CPU +: NUM_CPU] <= '0;
      else if (route_wr && route_idx == IDX_W'(n))
        route[n*NUM_CPU +: NUM_CPU] <= route_val;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      always_ff @(posedge clk) begin
        if (!rst_n) cpu_mask[c*NUM_SRC+n] <= 1'b1;
        else if (msk_set && cpu == CPU_W'(c) && num == IDX_W'(n))
          cpu_mask[c*NUM_SRC+n] <= 1'b1;
        else if (msk_clr && cpu == CPU_W'(c) && num == IDX_W'(n))
          cpu_mask[c*NUM_SRC+n] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import twolvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] elig,
  output logic [ID_W-1:0]    id,
  output logic               any
);
  always_comb begin
    id = NO_IRQ;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) id = ID_W'(i);
    end
  end
  assign any = |elig;
endmodule

// File: rtl/twolvl_irq_ctrl.sv
module twolvl_irq_ctrl
  import twolvl_irq_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int NUM_CPU    = 4,
  parameter int LOCAL_LAST = 28,
  parameter int ADDR_W     = 14,
  parameter int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] irq_req
);
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int ROUTE_END = 32'h100 + 4 * NUM_SRC;

  logic [12:0] off;
  logic        in_bank;
  logic        num_ok, cpu_ok, rt_hit;
  logic [12:0] rt_rel;
  logic [IDX_W-1:0] rt_idx, wr_num;
  logic wr_en_set, wr_en_clr, wr_msk_set, wr_msk_clr, wr_route;

  assign off     = bus_addr[12:0];
  assign in_bank = bus_addr[ADDR_W-1];
  assign num_ok  = num_in_range(bus_wdata, NUM_SRC);
  assign cpu_ok  = 32'(bus_cpu) < 32'(NUM_CPU);
  assign rt_rel  = off - OFF_ROUTE;
  assign rt_hit  = !in_bank && off >= OFF_ROUTE && 32'(off) < ROUTE_END && off[1:0] == 2'b00;
  assign rt_idx  = rt_rel[IDX_W+1:2];
  assign wr_num  = bus_wdata[IDX_W-1:0];

  assign wr_en_set  = bus_wr && !in_bank && off == OFF_EN_SET && num_ok;
  assign wr_en_clr  = bus_wr && !in_bank && off == OFF_EN_CLR && num_ok;
  assign wr_msk_set = bus_wr && in_bank && off == OFF_MSK_SET && num_ok && cpu_ok;
  assign wr_msk_clr = bus_wr && in_bank && off == OFF_MSK_CLR && num_ok && cpu_ok;
  assign wr_route   = bus_wr && rt_hit;

  logic [NUM_SRC-1:0]         gen_en;
  logic [NUM_CPU*NUM_SRC-1:0] cpu_mask;
  logic [NUM_SRC*NUM_CPU-1:0] route;

  irq_state_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CPU_W(CPU_W)
  ) state_i (
    .clk(clk), .rst_n(rst_n),
    .en_set(wr_en_set), .en_clr(wr_en_clr),
    .msk_set(wr_msk_set), .msk_clr(wr_msk_clr),
    .route_wr(wr_route), .cpu(bus_cpu), .num(wr_num),
    .route_idx(rt_idx), .route_val(bus_wdata[NUM_CPU-1:0]),
    .gen_en(gen_en), .cpu_mask(cpu_mask), .route(route)
  );

  logic [ID_W-1:0]         pick_id [NUM_CPU];
  logic [NUM_CPU*ID_W-1:0] pick_flat;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] elig;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (route_applies(n, LOCAL_LAST)) begin : g_routed
        assign elig[n] = src_lvl[n] & gen_en[n] & ~cpu_mask[c*NUM_SRC+n] & route[n*NUM_CPU+c];
      end else begin : g_local
        assign elig[n] = src_lvl[n] & gen_en[n] & ~cpu_mask[c*NUM_SRC+n];
      end
    end
    irq_pick #(.NUM_SRC(NUM_SRC)) pick_i (
      .elig(elig), .id(pick_id[c]), .any(irq_req[c])
    );
    assign pick_flat[c*ID_W +: ID_W] = pick_id[c];
  end

  logic [NUM_CPU-1:0] route_rd;
  logic [31:0]        rd_val;
  assign route_rd = route[rt_idx*NUM_CPU +: NUM_CPU];

  always_comb begin
    rd_val = '0;
    if (!in_bank) begin
      if (off == OFF_CTRL) rd_val = ctrl_word(NUM_SRC);
      else if (rt_hit)     rd_val = 32'(route_rd);
    end else if (off == OFF_ACK) begin
      rd_val = cpu_ok ? 32'(pick_id[bus_cpu]) : 32'(NO_IRQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/twolvl_irq_chk.sv
module twolvl_irq_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 6,
  parameter int CPU_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_rd,
  input logic [31:0]                bus_rdata,
  input logic                       wr_en_set,
  input logic                       wr_en_clr,
  input logic                       wr_msk_set,
  input logic                       wr_msk_clr,
  input logic [CPU_W-1:0]           bus_cpu,
  input logic [IDX_W-1:0]           wr_num,
  input logic [NUM_SRC-1:0]         gen_en,
  input logic [NUM_CPU*NUM_SRC-1:0] cpu_mask,
  input logic [NUM_SRC-1:0]         src_lvl,
  input logic [NUM_CPU-1:0]         irq_req,
  input logic [NUM_CPU*10-1:0]      pick_flat
);
  localparam logic [NUM_SRC-1:0]         ONE_S = 1;
  localparam logic [NUM_CPU*NUM_SRC-1:0] ONE_M = 1;

  p_en_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> |((gen_en >> $past(wr_num)) & ONE_S));

  p_en_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> !(|((gen_en >> $past(wr_num)) & ONE_S)));

  p_msk_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk_set |=> |((cpu_mask >> (int'($past(bus_cpu)) * NUM_SRC + int'($past(wr_num)))) & ONE_M));

  p_msk_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_msk_clr |=> !(|((cpu_mask >> (int'($past(bus_cpu)) * NUM_SRC + int'($past(wr_num)))) & ONE_M)));

  p_pick_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> |((src_lvl >> pick_flat[9:0]) & ONE_S));

  p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req[0] |-> pick_flat[9:0] == 10'd1023);

  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'd0);
endmodule

bind twolvl_irq_ctrl twolvl_irq_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .CPU_W(CPU_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .wr_en_set(wr_en_set), .wr_en_clr(wr_en_clr),
  .wr_msk_set(wr_msk_set), .wr_msk_clr(wr_msk_clr),
  .bus_cpu(bus_cpu), .wr_num(wr_num), .gen_en(gen_en),
  .cpu_mask(cpu_mask), .src_lvl(src_lvl), .irq_req(irq_req),
  .pick_flat(pick_flat)
);

// File: tb/twolvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module twolvl_irq_ctrl_tb_top;
  localparam int NSRC = 64;
  localparam int NCPU = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_lvl = '1;
  logic [1:0]      bus_cpu = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [13:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCPU-1:0] irq_req;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  twolvl_irq_ctrl #(.NUM_SRC(NSRC), .NUM_CPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_cpu(bus_cpu),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  typedef struct packed {
    logic        rd;
    logic [1:0]  cpu;
    logic [13:0] addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 14'h0000, 32'd256,  4'd5},  // R5 config word
    '{1'b1, 2'd0, 14'h2044, 32'd1023, 4'd9},  // R9 all masked after reset
    '{1'b1, 2'd0, 14'h01A0, 32'd0,    4'd9},  // R9 routing cleared
    '{1'b0, 2'd0, 14'h0030, 32'd40,   4'd1},  // R1 enable 40
    '{1'b0, 2'd0, 14'h01A0, 32'd2,    4'd3},  // R3 route 40 to cpu1
    '{1'b0, 2'd1, 14'h204C, 32'd40,   4'd2},  // R2 unmask 40 for cpu1
    '{1'b1, 2'd1, 14'h2044, 32'd40,   4'd6},  // R6
    '{1'b1, 2'd0, 14'h2044, 32'd1023, 4'd2},  // R2 cpu0 still masked
    '{1'b0, 2'd0, 14'h204C, 32'd40,   4'd2},
    '{1'b1, 2'd0, 14'h2044, 32'd1023, 4'd3},  // R3 not routed to cpu0
    '{1'b0, 2'd0, 14'h0030, 32'd5,    4'd1},
    '{1'b0, 2'd2, 14'h204C, 32'd5,    4'd2},
    '{1'b1, 2'd2, 14'h2044, 32'd5,    4'd4},  // R4 local source, no route
    '{1'b0, 2'd1, 14'h204C, 32'd5,    4'd2},
    '{1'b1, 2'd1, 14'h2044, 32'd5,    4'd6},  // R6 lowest wins
    '{1'b0, 2'd1, 14'h2048, 32'd5,    4'd2},
    '{1'b1, 2'd1, 14'h2044, 32'd40,   4'd2},  // R2 mask hides 5
    '{1'b1, 2'd2, 14'h2044, 32'd5,    4'd7},  // R7 repeat read unchanged
    '{1'b0, 2'd0, 14'h0034, 32'd40,   4'd1},
    '{1'b1, 2'd1, 14'h2044, 32'd1023, 4'd1},  // R1 disabled
    '{1'b0, 2'd0, 14'h0030, 32'd104,  4'd1},
    '{1'b1, 2'd1, 14'h2044, 32'd1023, 4'd1},  // R1 out-of-range ignored
    '{1'b1, 2'd0, 14'h01A0, 32'd2,    4'd3},  // R3 readback
    '{1'b1, 2'd3, 14'h2044, 32'd1023, 4'd2}   // R2 cpu3 untouched
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] cpu, input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] cpu, input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 irq_req after reset", 32'(irq_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_read(VEC[i].cpu, VEC[i].addr, rv);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].data);
      end else begin
        bus_write(VEC[i].cpu, VEC[i].addr, VEC[i].data);
      end
    end

    check("R8 irq_req pattern", 32'(irq_req), 32'b0100);
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 32'd0);

    src_lvl[5] = 1'b0;
    bus_read(2'd2, 14'h2044, rv);
    check("R7 drop input clears ack", rv, 32'd1023);
    check("R8 irq_req follows input", 32'(irq_req), 32'd0);
    src_lvl[5] = 1'b1;
    bus_read(2'd2, 14'h2044, rv);
    check("R7 reasserted input", rv, 32'd5);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(2'd2, 14'h2044, rv);
    check("R9 ack after second reset", rv, 32'd1023);
    bus_read(2'd0, 14'h01A0, rv);
    check("R9 route after second reset", rv, 32'd0);
    check("R9 irq_req after second reset", 32'(irq_req), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule